// File: doc/BRIEF.md
# Line Zero-Crossing Supervisor and Period Meter

This block watches a stream of filtered voltage samples and turns the sign of each valid sample into a square wave. The wave is high while the line sits in its positive half and low while it sits in its negative half. Every sign change between two consecutive valid samples counts as a crossing. Each crossing reloads a prescaled down-counter from a programmable timeout value. If that counter drains to zero before the next crossing arrives, the block reports a lost line.

The report takes three forms:
- a one-cycle status pulse, which always fires;
- an interrupt pulse, which fires only when enabled;
- an active-low contribution to the sag pin, which is held low until the next crossing unless it is disabled.

Alongside the supervisor, a second prescaled counter measures the number of ticks between successive positive-going crossings. The result is published as a period register that saturates at its top value. The timeout counter starts from its all-ones value at reset, so a missing line is also reported after power-up when no reload has happened yet.

Top module: `zx_watch`

## Requirements
- R1: After reset `zx_level` is 0, `sag_n` is 1, `tmo_pulse` and `tmo_irq` are 0 and `period` is 0. The timeout counter starts at all ones (FFFh for 12 bits), so with no crossing `tmo_pulse` first fires (2^TO_W - 1) * TO_DIV cycles after reset is released.
- R2: A sample is negative when its most significant bit (two's complement sign) is 1; zero counts as non-negative. `zx_level` goes to 1 on a negative-to-non-negative crossing and to 0 on a non-negative-to-negative crossing. It is visible in the cycle after the crossing sample is accepted.
- R3: A crossing is recognised only between two consecutive valid samples; data presented while `smp_valid` is 0 is ignored. The first valid sample after reset never makes a crossing.
- R4: The timeout counter decrements once every TO_DIV clock cycles. Each crossing, in either direction, reloads it from `tmo_reload` and restarts the prescaler. Reloading with N > 0 makes `tmo_pulse` high for exactly one cycle, N * TO_DIV cycles after the crossing edge, unless another crossing comes first.
- R5: After expiry the counter stays at zero and no further `tmo_pulse` fires until a crossing reloads it. A reload value of 0 never expires.
- R6: When `sag_dis` is 0, `sag_n` goes low in the same cycle as `tmo_pulse` and stays low until the next crossing. When `sag_dis` is 1, `sag_n` stays high, but `tmo_pulse` still fires.
- R7: `tmo_irq` pulses together with `tmo_pulse` when `irq_en` is 1, and stays 0 when `irq_en` is 0.
- R8: The period counter advances once every PER_DIV cycles and restarts at each positive-going crossing. At each positive-going crossing except the first after reset, `period` takes the count reached. For crossing edges D cycles apart, the captured count is floor((D-1)/PER_DIV).
- R9: The period count saturates at all ones (2^PER_W - 1) instead of wrapping.
- R10: A negative-going crossing leaves `period` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data | input | SMP_W | Filtered voltage sample, two's complement |
| smp_valid | input | 1 | Sample strobe, one cycle per sample |
| tmo_reload | input | TO_W | Timeout reload value, in prescaled ticks |
| sag_dis | input | 1 | 1 keeps the timeout off the sag pin |
| irq_en | input | 1 | Enables the timeout interrupt pulse |
| zx_level | output | 1 | Square-wave zero-crossing level |
| tmo_pulse | output | 1 | One-cycle pulse on timeout expiry |
| tmo_irq | output | 1 | Timeout interrupt pulse, gated by irq_en |
| sag_n | output | 1 | Active-low timeout contribution to the sag pin |
| period | output | PER_W | Last measured line period in prescaled ticks |

## Verification
The bench builds the block with TO_DIV = 4, PER_DIV = 2 and PER_W = 10, keeping the 12-bit timeout and 16-bit samples. At these values the full power-up timeout from FFFh takes 16380 cycles, which is short enough to check exactly. The saturation of the period register also comes within reach after about two thousand cycles between positive crossings. Short reload values then show the exact expiry cycle, the parking at zero, and the sag and interrupt gating. A long random sample stream with random idle gaps checks the square wave and every period capture against a bench model.

// File: rtl/zx_watch.sv
module zx_watch #(
  parameter int SMP_W   = 16,
  parameter int TO_W    = 12,
  parameter int TO_DIV  = 128,
  parameter int PER_W   = 15,
  parameter int PER_DIV = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             smp_valid,
  input  logic [TO_W-1:0]  tmo_reload,
  input  logic             sag_dis,
  input  logic             irq_en,
  output logic             zx_level,
  output logic             tmo_pulse,
  output logic             tmo_irq,
  output logic             sag_n,
  output logic [PER_W-1:0] period
);

  localparam int TDW = (TO_DIV  > 1) ? $clog2(TO_DIV)  : 1;
  localparam int PDW = (PER_DIV > 1) ? $clog2(PER_DIV) : 1;
  localparam logic [TDW-1:0] TD_LAST = TDW'(TO_DIV - 1);
  localparam logic [PDW-1:0] PD_LAST = PDW'(PER_DIV - 1);

  logic have_prev, last_neg;
  wire  smp_neg  = smp_data[SMP_W-1];
  wire  xing     = smp_valid & have_prev & (smp_neg ^ last_neg);
  wire  xing_pos = xing & ~smp_neg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      have_prev <= 1'b0;
      last_neg  <= 1'b0;
      zx_level  <= 1'b0;
    end else if (smp_valid) begin
      have_prev <= 1'b1;
      last_neg  <= smp_neg;
      if (xing) zx_level <= ~smp_neg;
    end

  logic [TDW-1:0]  to_pre;
  logic [TO_W-1:0] to_cnt;
  logic            expired;
  wire  to_tick = (to_pre == TD_LAST);
  wire  to_last = to_tick & (to_cnt == TO_W'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      to_pre    <= '0;
      to_cnt    <= '1;
      expired   <= 1'b0;
      tmo_pulse <= 1'b0;
    end else if (xing) begin
      to_pre    <= '0;
      to_cnt    <= tmo_reload;
      expired   <= 1'b0;
      tmo_pulse <= 1'b0;
    end else begin
      to_pre    <= to_tick ? '0 : to_pre + 1'b1;
      if (to_tick && to_cnt != '0) to_cnt <= to_cnt - 1'b1;
      tmo_pulse <= to_last;
      if (to_last) expired <= 1'b1;
    end

  assign sag_n   = ~(expired & ~sag_dis);
  assign tmo_irq = tmo_pulse & irq_en;

  logic [PDW-1:0]   per_pre;
  logic [PER_W-1:0] per_cnt;
  logic             armed;
  wire  per_tick = (per_pre == PD_LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      per_pre <= '0;
      per_cnt <= '0;
      armed   <= 1'b0;
      period  <= '0;
    end else if (xing_pos) begin
      per_pre <= '0;
      per_cnt <= '0;
      armed   <= 1'b1;
      if (armed) period <= per_cnt;
    end else begin
      per_pre <= per_tick ? '0 : per_pre + 1'b1;
      if (per_tick && !(&per_cnt)) per_cnt <= per_cnt + 1'b1;
    end

endmodule

module zx_watch_chk #(
  parameter int PER_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             sag_dis,
  input logic             zx_level,
  input logic             tmo_pulse,
  input logic             sag_n,
  input logic [PER_W-1:0] period
);

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_pulse |=> !tmo_pulse);

  assert_sag_on_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_pulse && !sag_dis) |-> !sag_n);

  assert_sag_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sag_n) && !sag_dis) |-> $past(smp_valid));

  assert_level_needs_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_valid) |-> $stable(zx_level));

  assert_period_on_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(period) |-> $rose(zx_level));

endmodule

bind zx_watch zx_watch_chk #(.PER_W(PER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .sag_dis(sag_dis),
  .zx_level(zx_level), .tmo_pulse(tmo_pulse), .sag_n(sag_n), .period(period)
);

// File: tb/zx_watch_test.sv
module zx_watch_test;
  localparam int SW = 16, TW = 12, TD = 4, PW = 10, PD = 2;
  localparam longint PMAX = (64'd1 << PW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [SW-1:0] smp = '0;
  logic          vld = 1'b0;
  logic [TW-1:0] reload = '1;
  logic          sdis = 1'b0, ien = 1'b1;
  logic          zx, tp, ti, sagn;
  logic [PW-1:0] per;

  zx_watch #(.SMP_W(SW), .TO_W(TW), .TO_DIV(TD), .PER_W(PW), .PER_DIV(PD)) uut (
    .clk(clk), .rst_n(rst_n), .smp_data(smp), .smp_valid(vld), .tmo_reload(reload),
    .sag_dis(sdis), .irq_en(ien), .zx_level(zx), .tmo_pulse(tp), .tmo_irq(ti),
    .sag_n(sagn), .period(per));

  int     n_chk = 0, n_bad = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint exp_period(input longint d);
    longint v = (d - 1) / PD;
    return (v > PMAX) ? PMAX : v;
  endfunction

  task automatic put(input int v, output longint edge_at);
    smp = SW'(v);
    vld = 1'b1;
    edge_at = cyc;
    step();
    vld = 1'b0;
    smp = SW'($urandom);
  endtask

  task automatic do_reset();
    vld = 1'b0;
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
  endtask

  task automatic watch(input int len, output int first, output int pcnt,
                       output int icnt, output int slow);
    first = -1; pcnt = 0; icnt = 0; slow = 0;
    for (int k = 1; k <= len; k++) begin
      step();
      if (tp) begin pcnt++; if (first < 0) first = k; end
      if (ti) icnt++;
      if (!sagn) slow++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int first, pcnt, icnt, slow;
    longint e, e1, e2;
    void'($urandom(32'd4217));

    // R1: reset state and power-up timeout from all ones
    step();
    chk("R1 zx_level at reset", zx, 0);
    chk("R1 sag_n at reset", sagn, 1);
    chk("R1 tmo_pulse at reset", tp, 0);
    chk("R1 tmo_irq at reset", ti, 0);
    chk("R1 period at reset", per, 0);
    rst_n = 1'b1;
    watch(4095 * TD + 20, first, pcnt, icnt, slow);
    chk("R1 first expiry cycle from FFFh", first, 4095 * TD);
    chk("R1 single power-up pulse", pcnt, 1);

    // R4 R5 R6 R7: short reload, full gating
    do_reset();
    reload = 12'd10; sdis = 1'b0; ien = 1'b1;
    put(-100, e);
    chk("R3 first sample makes no crossing", zx, 0);
    put(100, e1);
    chk("R2 rise on positive crossing", zx, 1);
    watch(70, first, pcnt, icnt, slow);
    chk("R4 expiry after N*TO_DIV", first, 40);
    chk("R5 only one pulse while parked", pcnt, 1);
    chk("R7 irq with enable", icnt, 1);
    chk("R6 sag low until crossing", slow, 31);
    put(-50, e);
    chk("R2 fall on negative crossing", zx, 0);
    chk("R6 sag released by crossing", sagn, 1);
    chk("R10 negative crossing keeps period", per, 0);
    sdis = 1'b1; ien = 1'b0;
    watch(70, first, pcnt, icnt, slow);
    chk("R4 reload restarts timeout", first, 40);
    chk("R6 pulse fires while sag disabled", pcnt, 1);
    chk("R6 sag held high when disabled", slow, 0);
    chk("R7 irq masked", icnt, 0);
    reload = '0;
    put(50, e2);
    chk("R8 period after reload test", per, exp_period(e2 - e1));
    watch(200, first, pcnt, icnt, slow);
    chk("R5 zero reload never expires", pcnt, 0);

    // R9: saturation, zero is non-negative
    do_reset();
    reload = '1; sdis = 1'b0; ien = 1'b1;
    put(-1, e);
    put(0, e1);
    chk("R2 zero sample counts as positive", zx, 1);
    repeat (2500) step();
    put(-1, e);
    step();
    put(1, e2);
    chk("R9 period saturates", per, PMAX);

    // R2 R3 R8 R10: random stream with gaps
    do_reset();
    reload = '1;
    begin
      bit     have = 1'b0, lneg = 1'b0, armed = 1'b0, exp_zx = 1'b0;
      longint lpos = 0, exp_per = 0;
      for (int i = 0; i < 400; i++) begin
        int gap = $urandom_range(0, 4);
        bit neg;
        int v;
        for (int g = 0; g < gap; g++) begin
          smp = SW'($urandom);
          step();
        end
        if (gap > 0) chk("R3 idle data ignored", zx, exp_zx);
        neg = ($urandom_range(0, 2) == 0) ? ~lneg : lneg;
        v = neg ? -(1 + $urandom_range(0, 1000)) : $urandom_range(0, 1000);
        put(v, e);
        if (have && neg != lneg) begin
          if (!neg) begin
            if (armed) exp_per = exp_period(e - lpos);
            armed = 1'b1;
            lpos = e;
            exp_zx = 1'b1;
          end else exp_zx = 1'b0;
        end
        have = 1'b1;
        lneg = neg;
        chk("R2 random zx_level", zx, exp_zx);
        chk("R8 random period (R10 on falls)", per, exp_per);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule